// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit carries out the hardware half of interrupt entry and return for a small processor. It sits between the control path and the memory bus. The control path supplies the current program counter and condition flags. The unit drives a single-word memory bus, one transfer at a time, and waits for a ready handshake on every transfer. When the unit accepts an interrupt request, it raises an acknowledge towards the device and takes the interrupt number that the device places on the read-data lines. It then pushes the flags and the program counter onto a downward-growing stack. Next it reads the handler address from a table of word-sized slots at the bottom of memory, at byte address four times the number, and hands that address to the control path as the new program counter.

A return request reverses the entry. The unit pops the saved program counter and then the flags, and hands both back to the control path in the same cycle. Between acceptance and the end of the return, further requests are not accepted, but they are not lost: one pending request is remembered and taken as soon as the return completes. Choosing among several devices, decoding instructions and saving general registers are left to other logic and to the handler.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is asserted and directly after it, `irq_ack`, `mem_req`, `pc_load` and `flags_load` are low, and the stack pointer starts at `STACK_TOP` (default 0xFF00).
- R2: On an accepted request, `irq_ack` is high for at least two cycles. While `irq_ack` is high, `mem_req` stays low. The interrupt number is `mem_rdata[VW-1:0]` in the cycle when `mem_rdy` is high during the second or later cycle of acknowledge, and the upper data bits are ignored.
- R3: Entry writes exactly two words, in this order: the flags, zero-extended (bit 3 = N, bit 2 = C, bit 1 = V, bit 0 = Z), to `STACK_TOP-4`, then the program counter to `STACK_TOP-8`. Both values are the ones present on `pc_in` and `flags_in` in the cycle the request was accepted. Every bus address is word aligned.
- R4: After the pushes, entry reads exactly one word, at byte address 4*n. `pc_load` then pulses for one cycle with `pc_out` equal to that word and `flags_load` low.
- R5: Once `mem_req` is raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_rdy` is high. Any number of wait cycles is allowed.
- R6: Return reads `STACK_TOP-8`, then `STACK_TOP-4`, and writes nothing. `pc_load` and `flags_load` then pulse together, with `pc_out` equal to the first word read and `flags_out` equal to bits [3:0] of the second.
- R7: From acceptance until the return completes, `irq_ack` does not rise again.
- R8: A request that arrives while the unit is busy or a handler is active is held, and it is accepted automatically after the return completes.
- R9: `ret_req` has no effect when no interrupt is active: no bus transfer, no acknowledge, no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request, a pulse or level, latched as pending |
| irq_ack | output | 1 | Acknowledge to the requesting device |
| ret_req | input | 1 | Return-from-interrupt request from the control path |
| pc_in | input | AW | Current program counter |
| flags_in | input | 4 | Current flags N,C,V,Z (bits 3..0) |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` into the program counter |
| flags_load | output | 1 | One-cycle strobe: load `flags_out` into the flags |
| pc_out | output | AW | New program counter value |
| flags_out | output | 4 | Restored flags |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, which also carries the interrupt number during acknowledge |
| mem_rdy | input | 1 | Transfer or number-capture complete |

## Verification
The assertions check properties that must hold on every cycle: bus requests stay stable until ready, the acknowledge never overlaps a bus transfer, addresses are word aligned, the load strobe lasts one cycle, the flag load never occurs without a PC load, and the acknowledge never rises while a handler is active. The bench scenarios are the only way to show the data results. Those are: the exact stack addresses and their order, the handler address taken from 4*n for every number, the values restored on return, a masked request being taken after the return, and a stray return having no effect. The bench sweeps all interrupt numbers with several memory wait counts.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int unsigned FLAG_W    = 4;
  localparam int unsigned WORD_STEP = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK,
    ST_CAP,
    ST_PUSHF,
    ST_PUSHPC,
    ST_FETCH,
    ST_LDPC,
    ST_POPPC,
    ST_POPF,
    ST_RESTORE
  } disp_state_e;
endpackage

// File: rtl/irq_disp_mask.sv
module irq_disp_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic accept,
  input  logic ret_done,
  output logic pend,
  output logic in_isr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      in_isr <= 1'b0;
    end else begin
      pend <= (pend & ~accept) | irq_req;
      if (accept)        in_isr <= 1'b1;
      else if (ret_done) in_isr <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_disp_sp.sv
module irq_disp_sp
  import irq_disp_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned STACK_TOP = 32'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_dec,
  input  logic          sp_inc,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] TOP_INIT = AW'(STACK_TOP);
  localparam logic [AW-1:0] STEP     = AW'(WORD_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)      sp <= TOP_INIT;
    else if (sp_dec) sp <= sp - STEP;
    else if (sp_inc) sp <= sp + STEP;
  end
endmodule

// File: rtl/irq_disp_seq.sv
module irq_disp_seq
  import irq_disp_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned VW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic              in_isr,
  input  logic              ret_req,
  input  logic [AW-1:0]     pc_in,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              mem_rdy,
  output logic              accept,
  output logic              ret_done,
  output logic              entry_done,
  output logic              sp_dec,
  output logic              sp_inc,
  output logic              irq_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     mem_wdata,
  output logic              pc_load,
  output logic              flags_load,
  output logic [AW-1:0]     pc_out,
  output logic [FLAG_W-1:0] flags_out
);
  localparam logic [AW-1:0] STEP = AW'(WORD_STEP);

  function automatic logic [AW-1:0] vec_slot(input logic [VW-1:0] n);
    return {{(AW-VW-2){1'b0}}, n, 2'b00};
  endfunction

  function automatic logic [AW-1:0] push_slot(input logic [AW-1:0] p);
    return p - STEP;
  endfunction

  disp_state_e       state;
  logic [VW-1:0]     num_q;
  logic [AW-1:0]     pc_q;
  logic [FLAG_W-1:0] fl_q;
  logic [AW-1:0]     tgt_q;
  logic [FLAG_W-1:0] rfl_q;
  logic              ret_go;
  logic              is_push;
  logic              is_pop;

  assign accept  = (state == ST_IDLE) && pend && !in_isr;
  assign ret_go  = (state == ST_IDLE) && in_isr && ret_req;
  assign is_push = (state == ST_PUSHF) || (state == ST_PUSHPC);
  assign is_pop  = (state == ST_POPPC) || (state == ST_POPF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      num_q <= '0;
      pc_q  <= '0;
      fl_q  <= '0;
      tgt_q <= '0;
      rfl_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            pc_q  <= pc_in;
            fl_q  <= flags_in;
            state <= ST_ACK;
          end else if (ret_go) begin
            state <= ST_POPPC;
          end
        end
        ST_ACK: state <= ST_CAP;
        ST_CAP: if (mem_rdy) begin
          num_q <= mem_rdata[VW-1:0];
          state <= ST_PUSHF;
        end
        ST_PUSHF:  if (mem_rdy) state <= ST_PUSHPC;
        ST_PUSHPC: if (mem_rdy) state <= ST_FETCH;
        ST_FETCH: if (mem_rdy) begin
          tgt_q <= mem_rdata;
          state <= ST_LDPC;
        end
        ST_LDPC: state <= ST_IDLE;
        ST_POPPC: if (mem_rdy) begin
          tgt_q <= mem_rdata;
          state <= ST_POPF;
        end
        ST_POPF: if (mem_rdy) begin
          rfl_q <= mem_rdata[FLAG_W-1:0];
          state <= ST_RESTORE;
        end
        ST_RESTORE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSHF: begin
        mem_addr  = push_slot(sp);
        mem_wdata = {{(AW-FLAG_W){1'b0}}, fl_q};
      end
      ST_PUSHPC: begin
        mem_addr  = push_slot(sp);
        mem_wdata = pc_q;
      end
      ST_FETCH: mem_addr = vec_slot(num_q);
      ST_POPPC, ST_POPF: mem_addr = sp;
      default: ;
    endcase
  end

  assign mem_req    = is_push || is_pop || (state == ST_FETCH);
  assign mem_we     = is_push;
  assign sp_dec     = is_push && mem_rdy;
  assign sp_inc     = is_pop && mem_rdy;
  assign irq_ack    = (state == ST_ACK) || (state == ST_CAP);
  assign entry_done = (state == ST_LDPC);
  assign ret_done   = (state == ST_RESTORE);
  assign pc_load    = entry_done || ret_done;
  assign flags_load = ret_done;
  assign pc_out     = tgt_q;
  assign flags_out  = rfl_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_disp_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned VW        = 4,
  parameter int unsigned STACK_TOP = 32'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  output logic          irq_ack,
  input  logic          ret_req,
  input  logic [AW-1:0] pc_in,
  input  logic [3:0]    flags_in,
  output logic          pc_load,
  output logic          flags_load,
  output logic [AW-1:0] pc_out,
  output logic [3:0]    flags_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_rdy
);
  logic          evt_accept;
  logic          evt_entry_done;
  logic          evt_ret_done;
  logic          pend_w;
  logic          in_isr_w;
  logic          sp_dec_w;
  logic          sp_inc_w;
  logic [AW-1:0] sp_w;

  irq_disp_mask u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .accept   (evt_accept),
    .ret_done (evt_ret_done),
    .pend     (pend_w),
    .in_isr   (in_isr_w)
  );

  irq_disp_sp #(.AW(AW), .STACK_TOP(STACK_TOP)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .sp_dec (sp_dec_w),
    .sp_inc (sp_inc_w),
    .sp     (sp_w)
  );

  irq_disp_seq #(.AW(AW), .VW(VW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend_w),
    .in_isr     (in_isr_w),
    .ret_req    (ret_req),
    .pc_in      (pc_in),
    .flags_in   (flags_in),
    .sp         (sp_w),
    .mem_rdata  (mem_rdata),
    .mem_rdy    (mem_rdy),
    .accept     (evt_accept),
    .ret_done   (evt_ret_done),
    .entry_done (evt_entry_done),
    .sp_dec     (sp_dec_w),
    .sp_inc     (sp_inc_w),
    .irq_ack    (irq_ack),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pc_load    (pc_load),
    .flags_load (flags_load),
    .pc_out     (pc_out),
    .flags_out  (flags_out)
  );
endmodule

// File: rtl/irq_disp_chk.sv
module irq_disp_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_rdy,
  input logic          pc_load,
  input logic          flags_load,
  input logic          in_isr
);
  AST_ACK_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ack) |-> !$past(in_isr)); // R7

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5

  AST_ACK_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && mem_req)); // R2

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R3

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load); // R4

  AST_FLAGS_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    flags_load |-> (pc_load && !mem_req && !irq_ack)); // R6
endmodule

bind irq_dispatch irq_disp_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_ack    (irq_ack),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rdy    (mem_rdy),
  .pc_load    (pc_load),
  .flags_load (flags_load),
  .in_isr     (in_isr_w)
);

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int unsigned AW  = 16;
  localparam int unsigned VW  = 4;
  localparam logic [15:0] TOP = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic        irq_ack;
  logic        ret_req = 1'b0;
  logic [15:0] pc_in = '0;
  logic [3:0]  flags_in = '0;
  logic        pc_load;
  logic        flags_load;
  logic [15:0] pc_out;
  logic [3:0]  flags_out;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;

  irq_dispatch #(.AW(AW), .VW(VW), .STACK_TOP(32'hFF00)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .ret_req(ret_req), .pc_in(pc_in), .flags_in(flags_in),
    .pc_load(pc_load), .flags_load(flags_load), .pc_out(pc_out),
    .flags_out(flags_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  int          wait_cfg = 0;
  logic [3:0]  dev_num = '0;
  int          cnt = 0;
  logic [15:0] start_addr = '0;
  int          r5_bad = 0;
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  int          ack_cnt = 0;
  int          bus_cnt = 0;
  int          load_cnt = 0;
  logic        ack_prev = 1'b0;
  logic [15:0] wr_addr [0:3];
  logic [15:0] wr_data [0:3];
  logic [15:0] rd_log  [0:3];
  logic [15:0] stk [logic [15:0]];

  function automatic logic [15:0] handler_of(input logic [3:0] n);
    return 16'h2000 + 16'(n) * 16'h0104;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus and device responder
  always @(negedge clk) begin
    mem_rdy = 1'b0;
    if (rst_n && (mem_req || irq_ack)) begin
      if (cnt == 0) start_addr = mem_addr;
      if (cnt >= wait_cfg) begin
        mem_rdy = 1'b1;
        cnt = 0;
        if (mem_req && mem_addr != start_addr) r5_bad++;
        if (irq_ack) begin
          mem_rdata = 16'hA5A0 | 16'(dev_num);
        end else if (mem_we) begin
          stk[mem_addr] = mem_wdata;
          if (wr_cnt < 4) begin wr_addr[wr_cnt] = mem_addr; wr_data[wr_cnt] = mem_wdata; end
          wr_cnt++;
        end else begin
          if (mem_addr < 16'h0100) mem_rdata = handler_of(mem_addr[5:2]);
          else if (stk.exists(mem_addr)) mem_rdata = stk[mem_addr];
          else mem_rdata = 16'h0000;
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
        end
      end else begin
        cnt++;
      end
    end else begin
      cnt = 0;
    end
    if (irq_ack && !ack_prev) ack_cnt++;
    ack_prev = irq_ack;
    if (mem_req) bus_cnt++;
    if (pc_load) load_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wait_load(input string tag, output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pc_load) begin ok = 1; return; end
    end
    chk({tag, " load timeout"}, 0, 1);
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
  endtask

  task automatic do_entry(input logic [3:0] n, input logic [15:0] pc, input logic [3:0] fl);
    bit ok;
    int acks0;
    dev_num = n; pc_in = pc; flags_in = fl;
    wr_cnt = 0; rd_cnt = 0; acks0 = ack_cnt;
    pulse_irq();
    wait_load("R4", ok);
    if (!ok) return;
    chk("R4 handler pc", 32'(pc_out), 32'(handler_of(n)));
    chk("R4 flags_load low on entry", 32'(flags_load), 0);
    chk("R4 single fetch", rd_cnt, 1);
    chk("R4 fetch addr 4n", 32'(rd_log[0]), 32'(n) * 4);
    chk("R2 one acknowledge", ack_cnt - acks0, 1);
    chk("R3 write count", wr_cnt, 2);
    chk("R3 flags slot", 32'(wr_addr[0]), 32'(TOP - 16'd4));
    chk("R3 flags value", 32'(wr_data[0]), 32'(fl));
    chk("R3 pc slot", 32'(wr_addr[1]), 32'(TOP - 16'd8));
    chk("R3 pc value", 32'(wr_data[1]), 32'(pc));
  endtask

  task automatic do_return(input logic [15:0] pc, input logic [3:0] fl);
    bit ok;
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    wait_load("R6", ok);
    if (!ok) return;
    chk("R6 restored pc", 32'(pc_out), 32'(pc));
    chk("R6 restored flags", 32'(flags_out), 32'(fl));
    chk("R6 flags_load with pc_load", 32'(flags_load), 1);
    chk("R6 no writes", wr_cnt, 0);
    chk("R6 read count", rd_cnt, 2);
    chk("R6 first pop addr", 32'(rd_log[0]), 32'(TOP - 16'd8));
    chk("R6 second pop addr", 32'(rd_log[1]), 32'(TOP - 16'd4));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(irq_ack), 0);
    chk("R1 req in reset", 32'(mem_req), 0);
    chk("R1 load in reset", 32'(pc_load | flags_load), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", 32'(irq_ack), 0);
    chk("R1 req after reset", 32'(mem_req), 0);
    chk("R1 load after reset", 32'(pc_load | flags_load), 0);

    // R9: stray return before any interrupt
    begin
      int b0, l0, a0;
      b0 = bus_cnt; l0 = load_cnt; a0 = ack_cnt;
      @(negedge clk); ret_req = 1'b1;
      @(negedge clk); ret_req = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 no bus on stray return", bus_cnt - b0, 0);
      chk("R9 no load on stray return", load_cnt - l0, 0);
      chk("R9 no ack on stray return", ack_cnt - a0, 0);
    end

    // R2 R3 R4 R6 R1(stack start): sweep numbers and wait counts
    for (int w = 0; w < 3; w++) begin
      for (int n = 0; n < 16; n++) begin
        logic [15:0] pc;
        logic [3:0]  fl;
        wait_cfg = w;
        pc = 16'h4000 + 16'(n) * 16'h0111 + 16'(w);
        fl = 4'(n + w * 5);
        do_entry(4'(n), pc, fl);
        repeat (2) @(negedge clk);
        do_return(pc, fl);
        repeat (2) @(negedge clk);
      end
    end

    // R7 R8: request inside handler is masked, then taken after return
    begin
      int a0;
      wait_cfg = 1;
      do_entry(4'd5, 16'h1234, 4'b1010);
      dev_num = 4'd9;
      a0 = ack_cnt;
      pulse_irq();
      repeat (30) @(negedge clk);
      chk("R7 no ack while handler active", ack_cnt - a0, 0);
      do_return(16'h1234, 4'b1010);
      begin
        bit ok;
        wr_cnt = 0; rd_cnt = 0;
        wait_load("R8", ok);
        if (ok) begin
          chk("R8 pending taken after return", 32'(pc_out), 32'(handler_of(4'd9)));
          chk("R8 pending entry fetch addr", 32'(rd_log[0]), 32'd36);
          chk("R8 pending saved pc", 32'(wr_data[1]), 32'(16'h1234));
        end
      end
      do_return(16'h1234, 4'b1010);
    end

    // R8: request during entry sequence held pending
    begin
      bit ok;
      wait_cfg = 2;
      dev_num = 4'd3; pc_in = 16'h0BEE; flags_in = 4'b0110;
      pulse_irq();
      repeat (3) @(negedge clk);
      @(negedge clk); irq_req = 1'b1;
      @(negedge clk); irq_req = 1'b0;
      wait_load("R8", ok);
      chk("R8 first entry handler", 32'(pc_out), 32'(handler_of(4'd3)));
      dev_num = 4'd12;
      do_return(16'h0BEE, 4'b0110);
      wait_load("R8", ok);
      chk("R8 second entry handler", 32'(pc_out), 32'(handler_of(4'd12)));
      do_return(16'h0BEE, 4'b0110);
    end

    // R9: stray return after all handlers finished
    begin
      int b0, l0;
      repeat (3) @(negedge clk);
      b0 = bus_cnt; l0 = load_cnt;
      @(negedge clk); ret_req = 1'b1;
      @(negedge clk); ret_req = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 idle return ignored bus", bus_cnt - b0, 0);
      chk("R9 idle return ignored load", load_cnt - l0, 0);
    end

    chk("R5 address held during waits", r5_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule